// File: doc/BRIEF.md
# Page Write Commit and Protection Controller

This block sits behind the serial command front end of a 512-byte nonvolatile memory. The front end reports every serial clock rising edge as a one-cycle pulse, hands over each completed byte on a valid/ready stream, and pulses a frame-end strobe when chip select returns high. From these the block decodes the first byte of the frame as a command. For array writes it gathers up to four data bytes into a page buffer, addressed by the low two bits of the start address. When the frame closes it decides whether the write is allowed to proceed.

A write proceeds only when all of the following hold: the write-enable latch was set in an earlier frame, the write-protect input is high, the serial clock count is on one of the legal byte boundaries, and the block is idle. It then holds write-in-progress high for a fixed number of clock cycles. In the first cycles of that window it stores the buffered bytes into the array, skipping any address covered by the block-lock setting. At the end it clears the write-enable latch. Status writes use the same path and update the block-lock and watchdog-period fields.

The byte stream obeys valid/ready rules: a byte is taken in any cycle where `in_valid` and `in_ready` are both high. `in_ready` is low for the whole write cycle. A serial bus cannot be stalled, so bytes, clock pulses and frame ends that arrive while `in_ready` is low are discarded. The whole frame they belong to is then ignored. The front end must not raise `frame_end` in the same cycle as `sck_tick` or `in_valid`. The `WRITE_TICKS` parameter must be at least 4.

Top module: `pwc_page_commit`

## Requirements
- R1: After reset `wip`, `wel`, `lock_bits` and `wdog_bits` are all 0 and `in_ready` is 1.
- R2: A frame whose first byte is 0x06 sets `wel` in the cycle after `frame_end` when `wp_n` is high. A frame whose first byte is 0x04 clears it. Neither of these frames writes the array, even when more bytes follow the command byte.
- R3: A first byte matching 0000_x010 is an array write, with bit 3 supplying address bit 8 and the second byte supplying address bits 7..0. The write starts only when all of these hold: `wel` is 1, `wp_n` is high at `frame_end`, and the frame had exactly 24, 32, 40 or 48 clock pulses. Otherwise `wip` stays 0 and the array and `wel` are unchanged.
- R4: Data byte k of an array write lands at the address whose bits 8..2 come from the start address and whose bits 1..0 are (start[1:0]+k) mod 4, so a write wraps inside its 4-byte page.
- R5: The block-lock value selects the protected range: 00 none, 01 addresses 0x180-0x1FF, 10 addresses 0x100-0x1FF, 11 all addresses. A protected byte is never altered. The write cycle still runs and the unprotected bytes of the same page are still written.
- R6: A first byte of 0x01 is a status write. It commits only with `wel` set, `wp_n` high and exactly 16 clock pulses. At the end of the cycle, bits 3..2 of the second byte become `lock_bits` and bits 5..4 become `wdog_bits`.
- R7: A committed write raises `wip` in the cycle after `frame_end` and holds it for exactly `WRITE_TICKS` cycles. When `wip` falls, `wel` is 0.
- R8: `wp_n` low clears `wel` one cycle later and keeps it clear. A write whose frame ends while `wp_n` is low is not started.
- R9: `wp_n` going low while `wip` is high neither shortens the cycle nor stops the data from being stored.
- R10: While `wip` is high, `in_ready` is 0 and any frame that overlaps the cycle has no effect on `wel`, the status fields or the array.
- R11: `rd_data` shows the array byte at `rd_addr` in the same cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sck_tick | input | 1 | One pulse per serial clock rising edge in the frame |
| in_valid | input | 1 | A complete received byte is offered |
| in_ready | output | 1 | Byte accepted when high; low during a write cycle |
| in_data | input | 8 | Received byte, first byte of frame is the command |
| frame_end | input | 1 | Pulse when chip select rises |
| wp_n | input | 1 | Write-protect, active low |
| rd_addr | input | 9 | Array read address |
| rd_data | output | 8 | Array read data |
| wip | output | 1 | Write cycle in progress |
| wel | output | 1 | Write-enable latch |
| lock_bits | output | 2 | Block-lock field |
| wdog_bits | output | 2 | Watchdog period field |

## Verification
`wel` responds to an enable or disable frame, and to `wp_n` going low, one clock after the sampling edge. `wip` rises one clock after the `frame_end` edge and falls `WRITE_TICKS` clocks after it rises. The array contents and the status fields are final once `wip` has fallen. The bench drives every input on the falling edge and samples on the falling edge. It counts the falling edges from the one that raised `frame_end`, checks `wip` at the first, the `WRITE_TICKS`-th and the following sample, and reads the page back through the combinational read port only after that.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  localparam int ADDR_W = 9;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_SET_WEL,
    CMD_CLR_WEL,
    CMD_STATUS_WR,
    CMD_ARRAY_WR
  } cmd_e;

  localparam logic [7:0] OPC_SET_WEL   = 8'h06;
  localparam logic [7:0] OPC_CLR_WEL   = 8'h04;
  localparam logic [7:0] OPC_STATUS_WR = 8'h01;
  localparam logic [7:0] OPC_ARR_MASK  = 8'hF7;
  localparam logic [7:0] OPC_ARR_WR    = 8'h02;
  localparam int         OPC_HI_BIT    = 3;

  function automatic cmd_e decode_cmd(logic [7:0] op);
    if ((op & OPC_ARR_MASK) == OPC_ARR_WR) return CMD_ARRAY_WR;
    case (op)
      OPC_SET_WEL:   return CMD_SET_WEL;
      OPC_CLR_WEL:   return CMD_CLR_WEL;
      OPC_STATUS_WR: return CMD_STATUS_WR;
      default:       return CMD_NONE;
    endcase
  endfunction

  // Top quarter, top half or whole array, picked by the lock field.
  function automatic logic is_locked(logic [ADDR_W-1:0] a, logic [1:0] lk);
    case (lk)
      2'b01:   return a[ADDR_W-1] & a[ADDR_W-2];
      2'b10:   return a[ADDR_W-1];
      2'b11:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/pwc_array.sv
module pwc_array #(
  parameter int DEPTH  = 512,
  parameter int DATA_W = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/pwc_frame_collect.sv
module pwc_frame_collect
  import pwc_pkg::*;
#(
  parameter int PAGE_BYTES = 4,
  localparam int PAGE_W  = $clog2(PAGE_BYTES),
  localparam int CNT_W   = $clog2(8 * (PAGE_BYTES + 3)),
  localparam int PIDX_W  = ADDR_W - PAGE_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        busy,
  input  logic                        sck_tick,
  input  logic                        in_valid,
  input  logic [7:0]                  in_data,
  input  logic                        frame_end,
  output logic                        frame_done,
  output cmd_e                        cmd,
  output logic [CNT_W-1:0]            bit_cnt,
  output logic [PIDX_W-1:0]           page_idx,
  output logic [PAGE_BYTES-1:0][7:0]  buf_data,
  output logic [PAGE_BYTES-1:0]       buf_mask,
  output logic [3:0]                  sr_fields
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [1:0]        byte_idx;
  logic [7:0]        opcode;
  logic [PAGE_W-1:0] ptr;
  logic              drop;
  logic              take;
  logic [ADDR_W-1:0] first_addr;

  assign take       = in_valid && !busy;
  assign first_addr = {opcode[OPC_HI_BIT], in_data};

  always_ff @(posedge clk) begin
    if (!rst_n || frame_end) begin
      byte_idx  <= '0;
      opcode    <= '0;
      ptr       <= '0;
      drop      <= 1'b0;
      bit_cnt   <= '0;
      page_idx  <= '0;
      sr_fields <= '0;
    end else begin
      if (busy && (sck_tick || in_valid)) drop <= 1'b1;
      if (!busy && sck_tick && bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
      if (take) begin
        case (byte_idx)
          2'd0: begin
            opcode   <= in_data;
            byte_idx <= 2'd1;
          end
          2'd1: begin
            page_idx  <= first_addr[ADDR_W-1:PAGE_W];
            ptr       <= in_data[PAGE_W-1:0];
            sr_fields <= in_data[5:2];
            byte_idx  <= 2'd2;
          end
          default: ptr <= ptr + 1'b1;
        endcase
      end
    end
  end

  for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
    logic [7:0] slot_q;
    logic       slot_v;
    always_ff @(posedge clk) begin
      if (!rst_n || frame_end) begin
        slot_q <= '0;
        slot_v <= 1'b0;
      end else if (take && byte_idx == 2'd2 && ptr == PAGE_W'(s)) begin
        slot_q <= in_data;
        slot_v <= 1'b1;
      end
    end
    assign buf_data[s] = slot_q;
    assign buf_mask[s] = slot_v;
  end

  assign frame_done = frame_end && !busy && !drop;
  assign cmd        = (byte_idx == 2'd0) ? CMD_NONE : decode_cmd(opcode);
endmodule

// File: rtl/pwc_write_seq.sv
module pwc_write_seq
  import pwc_pkg::*;
#(
  parameter int PAGE_BYTES  = 4,
  parameter int WRITE_TICKS = 2_500_000,
  localparam int PAGE_W = $clog2(PAGE_BYTES),
  localparam int PIDX_W = ADDR_W - PAGE_W,
  localparam int TICK_W = $clog2(WRITE_TICKS + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       start_status,
  input  logic [PIDX_W-1:0]          page_idx,
  input  logic [PAGE_BYTES-1:0][7:0] data,
  input  logic [PAGE_BYTES-1:0]      mask,
  input  logic [3:0]                 sr_fields,
  input  logic [1:0]                 lock_bits,
  output logic                       wip,
  output logic                       done,
  output logic                       sr_commit,
  output logic [3:0]                 sr_value,
  output logic                       mem_we,
  output logic [ADDR_W-1:0]          mem_addr,
  output logic [7:0]                 mem_wdata
);
  localparam logic [PAGE_W:0] SLOT_END = (PAGE_W + 1)'(PAGE_BYTES);

  logic [TICK_W-1:0]          cnt;
  logic [PAGE_W:0]            slot;
  logic                       status_q;
  logic [PIDX_W-1:0]          page_q;
  logic [PAGE_BYTES-1:0][7:0] data_q;
  logic [PAGE_BYTES-1:0]      mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wip      <= 1'b0;
      cnt      <= '0;
      slot     <= '0;
      status_q <= 1'b0;
      page_q   <= '0;
      data_q   <= '0;
      mask_q   <= '0;
      sr_value <= '0;
    end else if (start && !wip) begin
      wip      <= 1'b1;
      cnt      <= TICK_W'(WRITE_TICKS - 1);
      slot     <= '0;
      status_q <= start_status;
      page_q   <= page_idx;
      data_q   <= data;
      mask_q   <= mask;
      sr_value <= sr_fields;
    end else if (wip) begin
      if (cnt == '0) wip <= 1'b0;
      else           cnt <= cnt - 1'b1;
      if (slot != SLOT_END) slot <= slot + 1'b1;
    end
  end

  assign done      = wip && cnt == '0;
  assign sr_commit = done && status_q;
  assign mem_addr  = {page_q, slot[PAGE_W-1:0]};
  assign mem_wdata = data_q[slot[PAGE_W-1:0]];
  assign mem_we    = wip && !status_q && slot != SLOT_END
                     && mask_q[slot[PAGE_W-1:0]]
                     && !is_locked(mem_addr, lock_bits);
endmodule

// File: rtl/pwc_commit_ctrl.sv
module pwc_commit_ctrl
  import pwc_pkg::*;
#(
  parameter int PAGE_BYTES = 4,
  localparam int CNT_W     = $clog2(8 * (PAGE_BYTES + 3)),
  localparam int ARR_MIN   = 24,
  localparam int ARR_MAX   = 8 * (PAGE_BYTES + 2),
  localparam int SR_BITS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wp_n,
  input  logic             frame_done,
  input  cmd_e             cmd,
  input  logic [CNT_W-1:0] bit_cnt,
  input  logic             seq_done,
  input  logic             sr_commit,
  input  logic [3:0]       sr_value,
  output logic             start,
  output logic             start_status,
  output logic             wel,
  output logic [1:0]       lock_bits,
  output logic [1:0]       wdog_bits
);
  logic arr_cnt_ok, sr_cnt_ok, arr_go, sr_go;

  assign arr_cnt_ok = int'(bit_cnt) >= ARR_MIN && int'(bit_cnt) <= ARR_MAX
                      && bit_cnt[2:0] == 3'd0;
  assign sr_cnt_ok  = int'(bit_cnt) == SR_BITS;
  assign arr_go     = cmd == CMD_ARRAY_WR  && arr_cnt_ok;
  assign sr_go      = cmd == CMD_STATUS_WR && sr_cnt_ok;

  assign start        = frame_done && wel && wp_n && (arr_go || sr_go);
  assign start_status = sr_go;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wel       <= 1'b0;
      lock_bits <= '0;
      wdog_bits <= '0;
    end else begin
      if (!wp_n || seq_done)                    wel <= 1'b0;
      else if (frame_done && cmd == CMD_SET_WEL) wel <= 1'b1;
      else if (frame_done && cmd == CMD_CLR_WEL) wel <= 1'b0;
      if (sr_commit) begin
        lock_bits <= sr_value[1:0];
        wdog_bits <= sr_value[3:2];
      end
    end
  end
endmodule

// File: rtl/pwc_page_commit.sv
module pwc_page_commit
  import pwc_pkg::*;
#(
  parameter int PAGE_BYTES  = 4,
  parameter int WRITE_TICKS = 2_500_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_tick,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              frame_end,
  input  logic              wp_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              wip,
  output logic              wel,
  output logic [1:0]        lock_bits,
  output logic [1:0]        wdog_bits
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int PIDX_W = ADDR_W - PAGE_W;
  localparam int CNT_W  = $clog2(8 * (PAGE_BYTES + 3));

  logic                       frame_done;
  cmd_e                       cmd;
  logic [CNT_W-1:0]           bit_cnt;
  logic [PIDX_W-1:0]          page_idx;
  logic [PAGE_BYTES-1:0][7:0] buf_data;
  logic [PAGE_BYTES-1:0]      buf_mask;
  logic [3:0]                 sr_fields;
  logic                       start, start_status, seq_done, sr_commit;
  logic [3:0]                 sr_value;
  logic                       mem_we;
  logic [ADDR_W-1:0]          mem_addr;
  logic [7:0]                 mem_wdata;

  assign in_ready = !wip;

  pwc_frame_collect #(.PAGE_BYTES(PAGE_BYTES)) i_collect (
    .clk(clk), .rst_n(rst_n), .busy(wip), .sck_tick(sck_tick),
    .in_valid(in_valid), .in_data(in_data), .frame_end(frame_end),
    .frame_done(frame_done), .cmd(cmd), .bit_cnt(bit_cnt),
    .page_idx(page_idx), .buf_data(buf_data), .buf_mask(buf_mask),
    .sr_fields(sr_fields)
  );

  pwc_commit_ctrl #(.PAGE_BYTES(PAGE_BYTES)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .frame_done(frame_done),
    .cmd(cmd), .bit_cnt(bit_cnt), .seq_done(seq_done),
    .sr_commit(sr_commit), .sr_value(sr_value), .start(start),
    .start_status(start_status), .wel(wel), .lock_bits(lock_bits),
    .wdog_bits(wdog_bits)
  );

  pwc_write_seq #(.PAGE_BYTES(PAGE_BYTES), .WRITE_TICKS(WRITE_TICKS)) i_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_status(start_status),
    .page_idx(page_idx), .data(buf_data), .mask(buf_mask),
    .sr_fields(sr_fields), .lock_bits(lock_bits), .wip(wip),
    .done(seq_done), .sr_commit(sr_commit), .sr_value(sr_value),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  pwc_array #(.DEPTH(DEPTH), .DATA_W(8)) i_array (
    .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
    .raddr(rd_addr), .rdata(rd_data)
  );
endmodule

// File: rtl/pwc_page_commit_chk.sv
module pwc_page_commit_chk
  import pwc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wp_n,
  input logic              frame_end,
  input logic              wip,
  input logic              wel,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [1:0]        lock_bits
);
  assert_store_in_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wip);

  assert_locked_untouched_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !is_locked(mem_addr, lock_bits));

  assert_wp_clears_wel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_n |=> !wel);

  assert_start_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> ($past(frame_end) && $past(wel) && $past(wp_n)));

  assert_wel_set_at_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(frame_end));

  assert_end_clears_wel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> !wel);
endmodule

bind pwc_page_commit pwc_page_commit_chk i_chk (
  .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .frame_end(frame_end),
  .wip(wip), .wel(wel), .mem_we(mem_we), .mem_addr(mem_addr),
  .lock_bits(lock_bits)
);

// File: tb/test_pwc_page_commit.sv
module test_pwc_page_commit;
  localparam int TICKS = 20;
  localparam int PB    = 4;

  logic       clk = 1'b0;
  logic       rst_n, sck_tick, in_valid, frame_end, wp_n;
  logic [7:0] in_data;
  logic [8:0] rd_addr;
  logic [7:0] rd_data;
  logic       in_ready, wip, wel;
  logic [1:0] lock_bits, wdog_bits;

  always #2 clk = ~clk;

  pwc_page_commit #(.PAGE_BYTES(PB), .WRITE_TICKS(TICKS)) i_pwc_page_commit (
    .clk(clk), .rst_n(rst_n), .sck_tick(sck_tick), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .frame_end(frame_end),
    .wp_n(wp_n), .rd_addr(rd_addr), .rd_data(rd_data), .wip(wip),
    .wel(wel), .lock_bits(lock_bits), .wdog_bits(wdog_bits)
  );

  int checks = 0, errors = 0;
  logic [7:0] mem_m [512];
  logic [1:0] lock_m = 2'b00, wdog_m = 2'b00;
  logic       wel_m = 1'b0;
  logic [7:0] fbuf [8];
  bit         wp_busy = 0, intrude = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit prot(int a, logic [1:0] lk);
    case (lk)
      2'b01:   return a >= 'h180;
      2'b10:   return a >= 'h100;
      2'b11:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic send(int nb, int ex);
    for (int i = 0; i < nb; i++)
      for (int b = 0; b < 8; b++) begin
        @(negedge clk); sck_tick = 1'b1; in_valid = (b == 7); in_data = fbuf[i];
      end
    for (int e = 0; e < ex; e++) begin
      @(negedge clk); sck_tick = 1'b1; in_valid = 1'b0;
    end
    @(negedge clk); sck_tick = 1'b0; in_valid = 1'b0; frame_end = 1'b1;
    @(negedge clk); frame_end = 1'b0;
  endtask

  task automatic check_status(string req);
    chk(req, "wel", int'(wel), int'(wel_m));
    chk(req, "lock_bits", int'(lock_bits), int'(lock_m));
    chk(req, "wdog_bits", int'(wdog_bits), int'(wdog_m));
  endtask

  task automatic check_page(int base, string req);
    for (int k = 0; k < PB; k++) begin
      rd_addr = 9'(base + k); #1;
      chk(req, $sformatf("array byte 0x%0h", base + k), int'(rd_data), int'(mem_m[base + k]));
    end
  endtask

  task automatic check_all(string req);
    int bad = 0;
    for (int a = 0; a < 512; a++) begin
      rd_addr = 9'(a); #1;
      if (rd_data !== mem_m[a]) bad++;
    end
    chk(req, "array mismatches", bad, 0);
  endtask

  task automatic do_frame(int nb, int ex, string req);
    int   bits   = nb * 8 + ex;
    logic [7:0] op = fbuf[0];
    bit   is_arr = ((op & 8'hF7) == 8'h02);
    bit   ok_arr = (bits == 24 || bits == 32 || bits == 40 || bits == 48);
    bit   commit = wel_m && wp_n && ((is_arr && ok_arr) || (op == 8'h01 && bits == 16));
    int   base   = (int'(op[3]) << 8) | (int'(fbuf[1]) & 'hFC);
    int   used   = 0;
    if (op == 8'h06 && wp_n) wel_m = 1'b1;
    else if (op == 8'h04)    wel_m = 1'b0;
    send(nb, ex);
    if (commit) begin
      chk("R7", "wip after frame end", int'(wip), 1);
      if (is_arr) begin
        for (int k = 0; k < nb - 2; k++) begin
          int a = base | ((int'(fbuf[1][1:0]) + k) & 3);
          if (!prot(a, lock_m)) mem_m[a] = fbuf[k + 2];
        end
      end else begin
        lock_m = fbuf[1][3:2];
        wdog_m = fbuf[1][5:4];
      end
      if (wp_busy) wp_n = 1'b0;
      if (intrude) begin
        chk("R10", "in_ready while busy", int'(in_ready), 0);
        fbuf[0] = 8'h06;
        send(1, 0);
        used = 10;
      end
      repeat (TICKS - 1 - used) @(negedge clk);
      chk("R7", "wip on last cycle", int'(wip), 1);
      @(negedge clk);
      chk("R7", "wip after cycle", int'(wip), 0);
      wel_m = 1'b0;
      if (wp_busy) wp_n = 1'b1;
      if (is_arr) check_page(base, req);
    end else begin
      chk(req, "wip stays low", int'(wip), 0);
    end
    check_status(req);
  endtask

  task automatic wren();
    fbuf[0] = 8'h06;
    do_frame(1, 0, "R2");
  endtask

  task automatic arr_write(int addr, int nb, int ex, int seed, string req);
    fbuf[0] = 8'h02 | 8'((addr >> 8) & 1) << 3;
    fbuf[1] = 8'(addr);
    for (int k = 2; k < 8; k++) fbuf[k] = 8'(seed * 7 + k * 13 + 1);
    do_frame(nb, ex, req);
  endtask

  task automatic sr_write(logic [7:0] v, int nb, string req);
    fbuf[0] = 8'h01; fbuf[1] = v;
    do_frame(nb, 0, req);
  endtask

  task automatic wp_drop(string req);
    wp_n = 1'b0; wel_m = 1'b0;
    @(negedge clk);
    chk(req, "wel after wp low", int'(wel), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; sck_tick = 1'b0; in_valid = 1'b0; frame_end = 1'b0;
    wp_n = 1'b1; in_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "wip", int'(wip), 0);
    chk("R1", "in_ready", int'(in_ready), 1);
    check_status("R1");

    // fill the array through full-page writes
    for (int p = 0; p < 128; p++) begin
      wren();
      arr_write(p * 4, 6, 0, p, "R4");
    end
    check_all("R11");

    arr_write('h040, 3, 0, 3, "R3");           // no enable latch
    wren();
    arr_write('h041, 3, 1, 4, "R3");           // 25 clocks, abort
    arr_write('h042, 5, 0, 5, "R3");           // 40 clocks, commit
    wren();
    arr_write('h0A6, 6, 0, 6, "R4");           // wrap from offset 2
    wren();
    arr_write('h1F3, 3, 0, 7, "R4");           // single byte at offset 3

    fbuf[0] = 8'h06; fbuf[1] = 8'h02; fbuf[2] = 8'h10; fbuf[3] = 8'h55; fbuf[4] = 8'h66;
    do_frame(5, 0, "R2");                       // enable frame with trailing bytes
    check_page('h010, "R2");
    fbuf[0] = 8'h04;
    do_frame(1, 0, "R2");

    wren(); sr_write(8'h14, 2, "R6");           // lock 01, wdog 01
    wren(); arr_write('h17C, 6, 0, 8, "R5");
    wren(); arr_write('h180, 6, 0, 9, "R5");
    wren(); sr_write(8'h08, 2, "R6");           // lock 10
    wren(); arr_write('h17C, 6, 0, 10, "R5");
    wren(); arr_write('h0FC, 6, 0, 11, "R5");
    wren(); sr_write(8'h0C, 2, "R6");           // lock 11
    wren(); arr_write('h000, 6, 0, 12, "R5");
    wren(); sr_write(8'h30, 2, "R6");           // lock 00, wdog 11
    wren(); sr_write(8'h0C, 3, "R6");           // 24 clocks, abort

    wren(); wp_drop("R8"); wp_n = 1'b1;
    wp_n = 1'b0; wren();                        // enable ignored while protected
    wp_n = 1'b1; wren();
    wp_n = 1'b0; wel_m = 1'b0;
    arr_write('h020, 6, 0, 13, "R8");
    wp_n = 1'b1;

    wren(); wp_busy = 1;
    arr_write('h030, 6, 0, 14, "R9");
    wp_busy = 0;
    wren(); intrude = 1;
    arr_write('h050, 6, 0, 15, "R10");
    intrude = 0;
    check_all("R11");

    for (int it = 0; it < 120; it++) begin
      int r = $urandom % 10;
      if (r < 3) wren();
      else if (r == 3) begin fbuf[0] = 8'h04; do_frame(1, 0, "R2"); end
      else if (r < 8) begin
        int nb = 2 + $urandom % 5;
        int ex = ($urandom % 4 == 0) ? $urandom % 8 : 0;
        if ($urandom % 10 < 7) wren();
        arr_write($urandom % 512, nb, ex, $urandom % 256, "R3");
      end else if (r == 8) begin
        if ($urandom % 10 < 7) wren();
        sr_write(8'($urandom), ($urandom % 4 == 0) ? 3 : 2, "R6");
      end else begin
        wp_drop("R8"); wp_n = 1'b1;
      end
    end
    check_all("R11");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule